// File: doc/BRIEF.md
# Lockable Flash Timebase Divider

This block holds the control register that sets the timebase used by flash program and erase steps. A programmable prescaler divides the bus clock by a value held in the register's divide field. It produces a single-cycle tick enable at roughly 1 MHz, which the flash sequencer uses to count out its timed steps. The register also carries a status flag that shows whether it has been configured since reset. A further bit, once set, freezes the divide value until the next reset.

Software writes the register through a write strobe and a data byte. A write is refused while a flash command is running, which the command-complete input shows by reading 0. While the flash reset sequence is active, writes are accepted even though the command-complete input is 0. The tick stays low until the register has been written once, so no timed step can start from an unconfigured divider.

Top module: `flash_tick_divider`

## Requirements
- R1: During reset and after reset, `rd_data` reads 0x00 and `tick` is 0.
- R2: Bit 7 of `rd_data` (loaded flag) reads 0 until the first accepted write since reset. From then on it reads 1. Bit 7 of `wr_data` has no effect on it.
- R3: Bit 6 of `rd_data` (lock) is set by an accepted write whose data bit 6 is 1. Writing 0 to it has no effect, and only reset clears it.
- R4: While the lock reads 1, accepted writes leave bits 5:0 (divide field) unchanged.
- R5: A write is accepted when `cmd_idle`=1 or `rst_seq`=1. When both are 0, the write changes nothing, the loaded flag included.
- R6: Once loaded, `tick` is a one-cycle pulse every (divide field + 1) clocks. Take an accepted write at clock edge E that loads the register or changes the divide field to D. The first pulse is in the cycle that begins at edge E+D.
- R7: An accepted write that changes the divide field restarts the tick phase as described in R6. A write that keeps the same value leaves the phase undisturbed.
- R8: `tick` is 0 whenever the loaded flag is 0.
- R9: A single accepted write that sets the lock while the lock is still 0 also stores its divide value.
- R10: The new register contents appear on `rd_data` in the cycle after the accepting edge. Reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| cmd_idle | input | 1 | Command-complete flag (1 = no command running) |
| rst_seq | input | 1 | Flash reset sequence active |
| rd_data | output | 8 | Register read value {loaded, lock, divide} |
| tick | output | 1 | Timebase tick enable |

## Verification
A register field is due one clock after the edge that accepts a write. Each tick is due D cycles after the accepting edge and every D+1 cycles after that, with no extra pipeline stage. The bench drives inputs 2 ns after a rising edge. A cycle model, updated on the same rising edges from the requirements, predicts the register and tick values. Both outputs are compared against it at every falling edge, so each result is sampled in the cycle where it is due.

// File: rtl/flash_tick_pkg.sv
package flash_tick_pkg;

  // Outcome of a bus write request in the current cycle
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_REFUSED = 2'd1,
    WR_OPEN    = 2'd2,
    WR_LOCKED  = 2'd3
  } wr_kind_e;

  // Register layout: status flag on top, lock below it, divide field below that
  function automatic int unsigned loaded_pos(int unsigned div_w);
    return div_w + 1;
  endfunction

  function automatic int unsigned lock_pos(int unsigned div_w);
    return div_w;
  endfunction

endpackage

// File: rtl/ftd_write_gate.sv
module ftd_write_gate
  import flash_tick_pkg::*;
(
  input  logic     wr_en,
  input  logic     cmd_idle,
  input  logic     rst_seq,
  input  logic     lock_q,
  output wr_kind_e wr_kind
);

  logic allowed;

  always_comb begin
    allowed = cmd_idle | rst_seq;
    if (!wr_en) begin
      wr_kind = WR_NONE;
    end else if (!allowed) begin
      wr_kind = WR_REFUSED;
    end else if (lock_q) begin
      wr_kind = WR_LOCKED;
    end else begin
      wr_kind = WR_OPEN;
    end
  end

endmodule

// File: rtl/ftd_ctrl_reg.sv
module ftd_ctrl_reg
  import flash_tick_pkg::*;
#(
  parameter int unsigned DIV_W = 6,
  localparam int unsigned REG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_kind_e         wr_kind,
  input  logic [REG_W-1:0] wr_data,
  output logic             loaded_q,
  output logic             lock_q,
  output logic [DIV_W-1:0] div_q,
  output logic             restart
);

  localparam int unsigned LOCK_BIT = lock_pos(DIV_W);

  logic             loaded_d;
  logic             lock_d;
  logic [DIV_W-1:0] div_d;
  logic             accept;
  logic             reg_en;

  always_comb begin
    accept   = (wr_kind == WR_OPEN) || (wr_kind == WR_LOCKED);
    loaded_d = loaded_q | accept;
    lock_d   = lock_q | (accept & wr_data[LOCK_BIT]);
    div_d    = (wr_kind == WR_OPEN) ? wr_data[DIV_W-1:0] : div_q;
    restart  = (wr_kind == WR_OPEN) && (wr_data[DIV_W-1:0] != div_q);
    reg_en   = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      lock_q   <= 1'b0;
      div_q    <= '0;
    end else if (reg_en) begin
      loaded_q <= loaded_d;
      lock_q   <= lock_d;
      div_q    <= div_d;
    end
  end

endmodule

// File: rtl/ftd_prescaler.sv
module ftd_prescaler #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    wrap = (cnt_q == div_q);
    if (!run || restart || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    tick = run & wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider
  import flash_tick_pkg::*;
#(
  parameter int unsigned DIV_W = 6,
  localparam int unsigned REG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cmd_idle,
  input  logic             rst_seq,
  output logic [REG_W-1:0] rd_data,
  output logic             tick
);

  wr_kind_e         wr_kind;
  logic             loaded_q;
  logic             lock_q;
  logic [DIV_W-1:0] div_q;
  logic             restart;

  ftd_write_gate u_gate (
    .wr_en    (wr_en),
    .cmd_idle (cmd_idle),
    .rst_seq  (rst_seq),
    .lock_q   (lock_q),
    .wr_kind  (wr_kind)
  );

  ftd_ctrl_reg #(.DIV_W(DIV_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_kind  (wr_kind),
    .wr_data  (wr_data),
    .loaded_q (loaded_q),
    .lock_q   (lock_q),
    .div_q    (div_q),
    .restart  (restart)
  );

  ftd_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (loaded_q),
    .restart (restart),
    .div_q   (div_q),
    .tick    (tick)
  );

  assign rd_data = {loaded_q, lock_q, div_q};

endmodule

// File: rtl/flash_tick_divider_chk.sv
module flash_tick_divider_chk #(
  parameter int unsigned DIV_W = 6,
  localparam int unsigned REG_W = DIV_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             cmd_idle,
  input logic             rst_seq,
  input logic [REG_W-1:0] rd_data,
  input logic             tick
);

  logic loaded, locked, ok_wr;
  assign loaded = rd_data[REG_W-1];
  assign locked = rd_data[DIV_W];
  assign ok_wr  = wr_en & (cmd_idle | rst_seq);

  a_r2_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);

  a_r2_loaded_set: assert property (@(posedge clk) disable iff (!rst_n)
    ok_wr |=> loaded);

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r4_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(rd_data[DIV_W-1:0]));

  a_r5_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cmd_idle && !rst_seq) |=> $stable(rd_data));

  a_r9_value_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && !locked) |=> (rd_data[DIV_W-1:0] == $past(wr_data[DIV_W-1:0])));

  a_r8_no_tick_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !tick);

  a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rd_data[DIV_W-1:0] != '0 && !wr_en) |=> !tick);

endmodule

bind flash_tick_divider flash_tick_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .cmd_idle (cmd_idle),
  .rst_seq  (rst_seq),
  .rd_data  (rd_data),
  .tick     (tick)
);

// File: tb/flash_tick_divider_test.sv
`timescale 1ns/1ps
module flash_tick_divider_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       cmd_idle;
  logic       rst_seq;
  logic [7:0] rd_data;
  logic       tick;

  int n_cmp = 0;
  int n_bad = 0;
  int n_cyc = 0;
  bit done  = 0;

  // reference state
  logic       m_loaded, m_lock;
  logic [5:0] m_div, m_cnt;

  always #5 clk = ~clk;

  flash_tick_divider uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_idle(cmd_idle), .rst_seq(rst_seq), .rd_data(rd_data), .tick(tick)
  );

  function automatic logic [7:0] exp_rd();
    return {m_loaded, m_lock, m_div};
  endfunction

  function automatic logic exp_tick();
    return m_loaded && (m_cnt == m_div);
  endfunction

  // cycle model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loaded <= 0; m_lock <= 0; m_div <= 0; m_cnt <= 0;
    end else begin
      logic acc;
      logic [5:0] nc;
      acc = wr_en && (cmd_idle || rst_seq);
      if (!m_loaded || m_cnt == m_div) nc = 0; else nc = m_cnt + 1;
      if (acc && !m_lock && wr_data[5:0] != m_div) nc = 0;
      m_cnt <= nc;
      if (acc) begin
        m_loaded <= 1'b1;
        if (wr_data[6]) m_lock <= 1'b1;
        if (!m_lock) m_div <= wr_data[5:0];
      end
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // continuous comparison at falling edges
  always @(negedge clk) begin
    n_cyc++;
    n_cmp++;
    if (rd_data !== exp_rd()) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%02h expected=%02h",
               !rst_n ? "R1" : "R2/R3/R4/R5/R10", rd_data, exp_rd());
    end
    n_cmp++;
    if (tick !== exp_tick()) begin
      n_bad++;
      $display("FAIL %s tick actual=%0b expected=%0b",
               !rst_n ? "R1" : (!m_loaded ? "R8" : "R6/R7"), tick, exp_tick());
    end
    if (n_cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", n_cyc);
      report();
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic write(logic [7:0] d, logic idl, logic seq);
    @(posedge clk); #2;
    wr_en = 1; wr_data = d; cmd_idle = idl; rst_seq = seq;
    @(posedge clk); #2;
    wr_en = 0; cmd_idle = 1; rst_seq = 0;
  endtask

  task automatic expect_rd(logic [7:0] e, string tag);
    @(negedge clk); #1;
    n_cmp++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s directed rd_data actual=%02h expected=%02h", tag, rd_data, e);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 0;
    idle(2);
    rst_n = 1;
  endtask

  initial begin
    int ticks;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; wr_en = 0; wr_data = 0; cmd_idle = 1; rst_seq = 0;
    idle(3);
    expect_rd(8'h00, "R1");
    rst_n = 1;
    idle(10);                         // R8: no tick while unloaded
    write(8'h05, 0, 0); expect_rd(8'h00, "R5");
    write(8'h03, 0, 1); expect_rd(8'h83, "R5");
    write(8'h82, 1, 0); expect_rd(8'h82, "R2");
    write(8'h47, 1, 0); expect_rd(8'hC7, "R9");
    write(8'h01, 1, 0); expect_rd(8'hC7, "R4");
    write(8'h00, 1, 0); expect_rd(8'hC7, "R3");
    do_reset(); expect_rd(8'h00, "R1");
    // R7: change mid-phase, then count R6 period
    write(8'h04, 1, 0); idle(2);
    write(8'h09, 1, 0);
    ticks = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); if (tick) ticks++;
    end
    n_cmp++;
    if (ticks != 10) begin
      n_bad++;
      $display("FAIL R6 tick count actual=%0d expected=10", ticks);
    end
    write(8'h09, 1, 0); idle(25);     // R7: same value keeps phase
    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      if ($urandom_range(0, 799) == 0) begin
        rst_n = 0; @(posedge clk); #2; rst_n = 1;
      end
      wr_en    = ($urandom_range(0, 9) == 0);
      wr_data  = {$urandom_range(0, 1) == 1'b1, $urandom_range(0, 15) == 0,
                  6'($urandom_range(0, 12))};
      cmd_idle = ($urandom_range(0, 3) != 0);
      rst_seq  = ($urandom_range(0, 5) == 0);
    end
    @(posedge clk); #2;
    wr_en = 0;
    idle(5);
    done = 1;
    report();
    $finish;
  end

endmodule